// File: doc/BRIEF.md
# FSM Watermark Signature Checker

This block tests whether a sequential device under test carries a hidden input/output signature. When started, it resets the device for one cycle. It then plays a stored list of 2-bit input symbols into the device, one per clock. Each 1-bit response is compared with a stored expected bit. The checker looks only at the device's reset, stimulus and response pins. It never uses any state inside the device.

The signature is divided into segments. Each segment begins at the device's reset state and ends back there, so the segment boundaries are fixed when the checker is built. Each segment is scored on its own. If one part of the signature has been altered, the parts that are still intact are still reported as present. At the end of a run the checker presents four results, which stay fixed until the next run begins:
- a match mask with one bit per segment,
- the number of matching segments,
- a full-match flag,
- a one-cycle done pulse.

The sequence length, the segment boundaries and both symbol lists are parameters. The checker supports up to 16 steps and up to 8 segments. The defaults describe a nine-step signature in three segments of three steps each.

Top module: `fsm_sig_checker`

## Requirements
- R1: A synchronous `rst` puts the checker in idle. In idle, `dut_rst` is 0, `dut_stim` is 00, `seg_match` is all zero, `match_cnt` is 0, `full_match` is 0 and `done` is 0.
- R2: A `start` sampled high while idle is accepted. In the cycle after the accepting edge, `dut_rst` is high, and it stays high for exactly that one cycle.
- R3: After the reset cycle, `dut_stim` carries step k's symbol in the k-th following cycle, one step per cycle, in step order. Step k is bits [2k+1:2k] of `STIM_SEQ`, and the default order is 01,01,00,10,01,00,11,10,01. Outside the stimulus cycles, `dut_stim` is 00.
- R4: The response bit present on `dut_resp` one cycle after step k's symbol is driven is compared with bit k of `EXP_SEQ`. The default expected list is 0,1,1,0,1,0,1,1,1 for steps 0 to 8.
- R5: A step k with bit k of `SEG_END` set is the last step of a segment. Bit j of `seg_match` (bit 0 is the first segment) is 1 only if every step of segment j matched. With the defaults, segment j covers steps 3j to 3j+2.
- R6: `match_cnt` equals the number of set bits in `seg_match`. `full_match` is 1 exactly when every segment matched.
- R7: `done` is high for a single cycle, N_STEPS+2 cycles after the accepting edge (edge 11 after it for the defaults). The results change at that same edge.
- R8: The results stay constant from `done` until the next accepted start. The accepted start clears them to zero at its own edge.
- R9: A `start` sampled from the accepting edge up to the edge before `done` is ignored. It causes no second device reset and no second `done`.
- R10: A `rst` in the middle of a run aborts the run. No `done` follows it, and the results stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a run |
| dut_rst | output | 1 | One-cycle reset request to the device under test |
| dut_stim | output | SYM_W | Stimulus symbol for the device |
| dut_resp | input | 1 | Response bit from the device |
| seg_match | output | N_SEGS | Per-segment match mask, bit 0 = first segment |
| match_cnt | output | $clog2(N_SEGS+1) | Number of matching segments |
| full_match | output | 1 | All segments matched |
| done | output | 1 | One-cycle pulse when the results are updated |

## Verification
The assertions check the following on every cycle:
- The device reset and `done` never last more than one cycle.
- No run begins again while the checker is busy.
- The full-match flag agrees with the segment count.
- The results do not move except at a start or at the end of a run.

Some properties can only be shown by the bench's scenarios:
- The exact stimulus order and the alignment of the response sample to it. The model device answers wrongly whenever a symbol arrives out of place, so a misaligned sample shows up as a wrong result.
- Which segment loses its bit when particular steps are corrupted.
- The abort on reset in mid-run.
- The latency from start to `done`.

// File: rtl/sig_chk_pkg.sv
package sig_chk_pkg;
    localparam int MAX_STEPS = 16;
    localparam int MAX_SEGS  = 8;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RST  = 2'd1,
        PH_RUN  = 2'd2,
        PH_WAIT = 2'd3
    } phase_e;
endpackage

// File: rtl/sig_chk_seq.sv
module sig_chk_seq
    import sig_chk_pkg::*;
#(
    parameter int N_STEPS = 9,
    parameter int SYM_W   = 2,
    parameter logic [N_STEPS*SYM_W-1:0] STIM_SEQ = '0,
    localparam int STEP_W = (N_STEPS > 1) ? $clog2(N_STEPS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              start_ok,
    output logic              dut_rst,
    output logic [SYM_W-1:0]  dut_stim,
    output logic              cmp_vld,
    output logic [STEP_W-1:0] cmp_idx
);
    localparam logic [STEP_W-1:0] LAST = STEP_W'(N_STEPS - 1);

    typedef struct packed {
        phase_e            phase;
        logic [STEP_W-1:0] step;
        logic              cmp_vld;
        logic [STEP_W-1:0] cmp_idx;
    } seq_regs_t;

    seq_regs_t d, q;

    always_comb begin
        d         = q;
        d.cmp_vld = 1'b0;
        case (q.phase)
            PH_IDLE: if (start) d.phase = PH_RST;
            PH_RST: begin
                d.phase = PH_RUN;
                d.step  = '0;
            end
            PH_RUN: begin
                d.cmp_vld = 1'b1;
                d.cmp_idx = q.step;
                if (q.step == LAST) d.phase = PH_WAIT;
                else                d.step  = q.step + 1'b1;
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign start_ok = (q.phase == PH_IDLE) && start;
    assign dut_rst  = (q.phase == PH_RST);
    assign dut_stim = (q.phase == PH_RUN) ? STIM_SEQ[int'(q.step)*SYM_W +: SYM_W] : '0;
    assign cmp_vld  = q.cmp_vld;
    assign cmp_idx  = q.cmp_idx;

    // R2
    dut_rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        dut_rst |=> !dut_rst);

    // R9
    no_restart_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (q.phase != PH_IDLE) |=> (q.phase != PH_RST));
endmodule

// File: rtl/sig_chk_score.sv
module sig_chk_score #(
    parameter int N_STEPS = 9,
    parameter int N_SEGS  = 3,
    parameter logic [N_STEPS-1:0] EXP_SEQ = '0,
    parameter logic [N_STEPS-1:0] SEG_END = '0,
    localparam int STEP_W = (N_STEPS > 1) ? $clog2(N_STEPS) : 1,
    localparam int SEG_W  = (N_SEGS > 1) ? $clog2(N_SEGS) : 1,
    localparam int CNT_W  = $clog2(N_SEGS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              arm,
    input  logic              cmp_vld,
    input  logic [STEP_W-1:0] cmp_idx,
    input  logic              resp,
    output logic [N_SEGS-1:0] seg_match,
    output logic [CNT_W-1:0]  match_cnt,
    output logic              full_match,
    output logic              done
);
    localparam logic [STEP_W-1:0] LAST = STEP_W'(N_STEPS - 1);

    typedef struct packed {
        logic [N_SEGS-1:0] work;
        logic [N_SEGS-1:0] res;
        logic [CNT_W-1:0]  cnt;
        logic              full;
        logic              done;
    } score_regs_t;

    score_regs_t d, q;
    logic [N_SEGS-1:0] nxt;
    logic              finish;

    function automatic logic [SEG_W-1:0] seg_of(input logic [STEP_W-1:0] k);
        int s = 0;
        for (int i = 0; i < N_STEPS; i++)
            if (i < int'(k) && SEG_END[i]) s++;
        return SEG_W'(s);
    endfunction

    function automatic logic [CNT_W-1:0] ones(input logic [N_SEGS-1:0] v);
        logic [CNT_W-1:0] c = '0;
        for (int i = 0; i < N_SEGS; i++) c = c + CNT_W'(v[i]);
        return c;
    endfunction

    assign finish = cmp_vld && (cmp_idx == LAST);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        nxt    = q.work;
        if (clear) begin
            d.res  = '0;
            d.cnt  = '0;
            d.full = 1'b0;
        end
        if (arm) d.work = '1;
        if (cmp_vld) begin
            if (resp != EXP_SEQ[cmp_idx]) nxt[seg_of(cmp_idx)] = 1'b0;
            d.work = nxt;
            if (finish) begin
                d.res  = nxt;
                d.cnt  = ones(nxt);
                d.full = &nxt;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign seg_match  = q.res;
    assign match_cnt  = q.cnt;
    assign full_match = q.full;
    assign done       = q.done;

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    full_count_chk: assert property (@(posedge clk) disable iff (rst)
        full_match |-> (int'(match_cnt) == N_SEGS));

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clear && !finish) |=> $stable(seg_match));
endmodule

// File: rtl/fsm_sig_checker.sv
module fsm_sig_checker #(
    parameter int N_STEPS = 9,
    parameter int N_SEGS  = 3,
    parameter int SYM_W   = 2,
    parameter logic [N_STEPS*SYM_W-1:0] STIM_SEQ =
        {2'b01, 2'b10, 2'b11, 2'b00, 2'b01, 2'b10, 2'b00, 2'b01, 2'b01},
    parameter logic [N_STEPS-1:0] EXP_SEQ = 9'b111010110,
    parameter logic [N_STEPS-1:0] SEG_END = 9'b100100100,
    localparam int CNT_W  = $clog2(N_SEGS + 1),
    localparam int STEP_W = (N_STEPS > 1) ? $clog2(N_STEPS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              dut_rst,
    output logic [SYM_W-1:0]  dut_stim,
    input  logic              dut_resp,
    output logic [N_SEGS-1:0] seg_match,
    output logic [CNT_W-1:0]  match_cnt,
    output logic              full_match,
    output logic              done
);
    logic              start_ok;
    logic              cmp_vld;
    logic [STEP_W-1:0] cmp_idx;

    sig_chk_seq #(
        .N_STEPS (N_STEPS),
        .SYM_W   (SYM_W),
        .STIM_SEQ(STIM_SEQ)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .start_ok(start_ok),
        .dut_rst (dut_rst),
        .dut_stim(dut_stim),
        .cmp_vld (cmp_vld),
        .cmp_idx (cmp_idx)
    );

    sig_chk_score #(
        .N_STEPS(N_STEPS),
        .N_SEGS (N_SEGS),
        .EXP_SEQ(EXP_SEQ),
        .SEG_END(SEG_END)
    ) u_score (
        .clk       (clk),
        .rst       (rst),
        .clear     (start_ok),
        .arm       (dut_rst),
        .cmp_vld   (cmp_vld),
        .cmp_idx   (cmp_idx),
        .resp      (dut_resp),
        .seg_match (seg_match),
        .match_cnt (match_cnt),
        .full_match(full_match),
        .done      (done)
    );
endmodule

// File: tb/fsm_sig_checker_test.sv
module fsm_sig_checker_test;
    localparam int N = 9;
    localparam logic [17:0] STIM = {2'b01, 2'b10, 2'b11, 2'b00, 2'b01, 2'b10, 2'b00, 2'b01, 2'b01};
    localparam logic [8:0]  EXP  = 9'b111010110;
    localparam int LAT = N + 3;   // negedges from the start-drive negedge until done is visible

    // {flip[8:0], mask[2:0], cnt[1:0], full}
    localparam int NV = 7;
    localparam logic [14:0] VECS [NV] = '{
        {9'b000000000, 3'b111, 2'd3, 1'b1},
        {9'b000111000, 3'b101, 2'd2, 1'b0},
        {9'b000000001, 3'b110, 2'd2, 1'b0},
        {9'b100000000, 3'b011, 2'd2, 1'b0},
        {9'b111111111, 3'b000, 2'd0, 1'b0},
        {9'b001000100, 3'b010, 2'd1, 1'b0},
        {9'b000001000, 3'b101, 2'd2, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       dut_rst;
    logic [1:0] dut_stim;
    logic       dut_resp;
    logic [2:0] seg_match;
    logic [1:0] match_cnt;
    logic       full_match;
    logic       done;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    fsm_sig_checker uut (
        .clk(clk), .rst(rst), .start(start),
        .dut_rst(dut_rst), .dut_stim(dut_stim), .dut_resp(dut_resp),
        .seg_match(seg_match), .match_cnt(match_cnt),
        .full_match(full_match), .done(done)
    );

    // model device: answers correctly only to the right symbol at the right step
    logic [4:0] m_cnt = '0;
    logic       m_resp = 1'b0;
    logic [8:0] flip_r = '0;
    assign dut_resp = m_resp;

    always_ff @(posedge clk) begin
        if (dut_rst) begin
            m_cnt  <= '0;
            m_resp <= 1'b0;
        end else begin
            if (m_cnt < 5'd31) m_cnt <= m_cnt + 1'b1;
            if (m_cnt < 5'(N))
                m_resp <= ((dut_stim == STIM[int'(m_cnt)*2 +: 2]) ? EXP[m_cnt[3:0]] : ~EXP[m_cnt[3:0]])
                          ^ flip_r[m_cnt[3:0]];
            else
                m_resp <= 1'b0;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run_vec(input logic [8:0] flip, input logic [2:0] emask,
                           input logic [1:0] ecnt, input logic efull);
        int lat;
        flip_r = flip;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        lat = 1;
        chk("R2 dut_rst in reset cycle", int'(dut_rst), 1);
        chk("R8 results cleared by start", int'(seg_match), 0);
        @(negedge clk) lat++;
        chk("R2 dut_rst lasts one cycle", int'(dut_rst), 0);
        chk("R3 first stimulus symbol", int'(dut_stim), int'(STIM[1:0]));
        while (!done && lat < 40) begin
            @(negedge clk) lat++;
        end
        chk("R7 done latency", lat, LAT);
        chk("R5 segment mask", int'(seg_match), int'(emask));
        chk("R6 match count", int'(match_cnt), int'(ecnt));
        chk("R6 full match", int'(full_match), int'(efull));
        repeat (3) @(negedge clk);
        chk("R7 done single cycle", int'(done), 0);
        chk("R8 mask held after done", int'(seg_match), int'(emask));
        chk("R3 stimulus idle value", int'(dut_stim), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 dut_rst", int'(dut_rst), 0);
        chk("R1 dut_stim", int'(dut_stim), 0);
        chk("R1 seg_match", int'(seg_match), 0);
        chk("R1 match_cnt", int'(match_cnt), 0);
        chk("R1 full_match", int'(full_match), 0);
        chk("R1 done", int'(done), 0);

        // R4 R5 R6: table of tamper patterns
        for (int v = 0; v < NV; v++)
            run_vec(VECS[v][14:6], VECS[v][5:3], VECS[v][2:1], VECS[v][0]);

        // R9: start while busy is ignored
        begin
            int lat;
            int n_rst;
            int n_done;
            flip_r = '0;
            @(negedge clk) start = 1'b1;
            @(negedge clk) start = 1'b0;
            lat = 1; n_rst = 0; n_done = 0;
            while (lat < 25) begin
                @(negedge clk) lat++;
                start = (lat == 3 || lat == 11);
                if (dut_rst) n_rst++;
                if (done) n_done++;
                if (done) chk("R9 done at normal latency", lat, LAT);
            end
            start = 1'b0;
            chk("R9 no second device reset", n_rst, 0);
            chk("R9 exactly one done", n_done, 1);
            chk("R9 result of first run", int'(seg_match), 7);
        end

        // R1: reset clears held results
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        chk("R1 seg_match after reset", int'(seg_match), 0);
        chk("R1 full_match after reset", int'(full_match), 0);

        // R10: abort mid-run
        begin
            int n_done;
            n_done = 0;
            @(negedge clk) start = 1'b1;
            @(negedge clk) start = 1'b0;
            repeat (4) @(negedge clk);
            rst = 1'b1;
            @(negedge clk) rst = 1'b0;
            repeat (15) begin
                @(negedge clk);
                if (done) n_done++;
            end
            chk("R10 no done after abort", n_done, 0);
            chk("R10 results zero after abort", int'(seg_match), 0);
            chk("R10 stimulus idle after abort", int'(dut_stim), 0);
        end

        // R4: the checker recovers for a clean run after the abort
        run_vec(9'b0, 3'b111, 2'd3, 1'b1);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule